// File: doc/BRIEF.md
# Wheel Speed Capture and Slip Ratio Unit

This block turns two squared tachometer pulse trains into wheel speeds and a braking slip ratio. One input comes from a front wheel that rolls freely and serves as the vehicle speed reference. The other input comes from the wheel being braked. Each sensor produces 50 pulses per wheel revolution. The sinusoidal sensor output is already squared to logic levels, at the same frequency, before it reaches this block.

For each channel, the input is first synchronised to the clock. A counter then measures how many clock cycles pass between two neighbouring rising edges. The speed is a constant divided by that count. The division is done by a sequential restoring divider. The two speeds are then combined into `(vref - vbrk) / vref`, also with a sequential divider. The result is an unsigned fraction with 16 fractional bits, limited to the range zero to full scale. It comes with a valid flag and a one-cycle done strobe.

A channel that sees no rising edge within a programmable number of cycles is treated as stopped. The first rising edge after reset, or after such a timeout, only re-arms the measurement.

Top module: `wheel_slip_meter`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all outputs are zero.
- R2: A channel's speed output equals floor(SPEED_K / P). Here P is the number of clock cycles between two consecutive rising edges on that channel's tachometer input. The value appears within SPD_W+8 cycles of the second edge.
- R3: The first rising edge after reset, or after a timeout, produces no speed value. The speed output stays zero until the next edge.
- R4: If a channel sees no rising edge for more than `timeout_i` cycles, its speed goes to zero and `slip_valid_o` goes low. An interval exactly equal to `timeout_i` is still measured.
- R5: When 0 < vbrk < vref, `slip_o` equals floor((vref - vbrk) * 65536 / vref) as unsigned Q0.16.
- R6: When vbrk >= vref, `slip_o` is 0 and is marked valid.
- R7: When vbrk is 0 and vref is greater than 0, `slip_o` is 16'hFFFF and is marked valid.
- R8: When the reference speed is zero, `slip_valid_o` is low from the next cycle on.
- R9: `slip_done_o` rises for one clock each time a new slip value is written, and `slip_valid_o` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tach_i | input | 1 | Squared pulse train from the freely rolling reference wheel |
| brk_tach_i | input | 1 | Squared pulse train from the braked wheel |
| timeout_i | input | CNT_W | Longest accepted interval between edges, in cycles |
| ref_speed_o | output | SPD_W | Reference wheel (vehicle) speed |
| brk_speed_o | output | SPD_W | Braked wheel speed |
| slip_o | output | FRAC_W | Slip ratio, unsigned Q0.16 |
| slip_valid_o | output | 1 | Slip value is meaningful |
| slip_done_o | output | 1 | One-cycle strobe when a new slip value is written |

## Verification
The bench builds the block with CNT_W=16, SPD_W=16, FRAC_W=16 and SPEED_K=5000. The small speed constant means a pulse period above 5000 cycles gives a speed quotient of zero. That makes both the full-scale slip case and the zero-reference invalid case reachable in a few tens of thousands of cycles. A 16-bit counter allows timeout values of 150 and 8000. The 150 setting lets the bench hit the exact timeout boundary with hand-placed pulses. The 8000 setting lets the slow periods pass without timing out.

// File: rtl/wheel_slip_pkg.sv
package wheel_slip_pkg;
  localparam int NUM_CH  = 2;
  localparam int REF_IDX = 0;
  localparam int BRK_IDX = 1;
endpackage

// File: rtl/wheel_edge_sync.sv
module wheel_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wheel_restoring_div.sv
module wheel_restoring_div #(
  parameter int N_W = 16,
  parameter int D_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [D_W-1:0] hi_i,
  input  logic [N_W-1:0] lo_i,
  input  logic [D_W-1:0] den_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N_W-1:0] quo_o
);
  localparam int STEP_W = $clog2(N_W + 1);

  logic [D_W-1:0]    rem_q;
  logic [N_W-1:0]    shf_q;
  logic [D_W-1:0]    den_q;
  logic [STEP_W-1:0] left_q;
  logic              busy_q;
  logic              done_q;
  logic [D_W:0]      trial;
  logic              take;

  always_comb begin
    trial = {rem_q, shf_q[N_W-1]};
    take  = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      shf_q  <= '0;
      den_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= hi_i;
        shf_q  <= lo_i;
        den_q  <= den_i;
        left_q <= STEP_W'(N_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= take ? D_W'(trial - {1'b0, den_q}) : trial[D_W-1:0];
        shf_q  <= {shf_q[N_W-2:0], take};
        left_q <= left_q - 1'b1;
        if (left_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = shf_q;
endmodule

// File: rtl/wheel_tach_channel.sv
module wheel_tach_channel #(
  parameter int CNT_W   = 20,
  parameter int SPD_W   = 16,
  parameter int SPEED_K = 50000,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tach_i,
  input  logic [CNT_W-1:0] timeout_i,
  output logic [SPD_W-1:0] speed_o,
  output logic             ok_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SPD_W-1:0] K_VAL   = SPD_W'(SPEED_K);

  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [SPD_W-1:0] speed_q;
  logic             ok_q;
  logic             upd_q;
  logic             tmo_hit;
  logic             div_start;
  logic             div_busy;
  logic             div_done;
  logic [SPD_W-1:0] div_quo;

  wheel_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d_i(tach_i), .rise_o(rise)
  );

  assign tmo_hit   = !rise && armed_q && (cnt_q >= timeout_i);
  assign div_start = rise && armed_q && !div_busy;

  wheel_restoring_div #(.N_W(SPD_W), .D_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .start_i(div_start),
    .hi_i('0), .lo_i(K_VAL), .den_i(cnt_q),
    .busy_o(div_busy), .done_o(div_done), .quo_o(div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      speed_q <= '0;
      ok_q    <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (rise) begin
        cnt_q   <= CNT_W'(1);
        armed_q <= 1'b1;
      end else if (tmo_hit) begin
        armed_q <= 1'b0;
        ok_q    <= 1'b0;
        speed_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (div_done && armed_q && !tmo_hit) begin
        speed_q <= div_quo;
        ok_q    <= 1'b1;
        upd_q   <= 1'b1;
      end
    end
  end

  assign speed_o = speed_q;
  assign ok_o    = ok_q;
  assign upd_o   = upd_q;
endmodule

// File: rtl/wheel_slip_calc.sv
module wheel_slip_calc #(
  parameter int SPD_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SPD_W-1:0]  vref_i,
  input  logic [SPD_W-1:0]  vbrk_i,
  input  logic              ref_ok_i,
  input  logic              brk_ok_i,
  input  logic              upd_i,
  output logic [FRAC_W-1:0] slip_o,
  output logic              valid_o,
  output logic              done_o
);
  localparam logic [FRAC_W-1:0] SLIP_FULL = '1;

  logic              live;
  logic              trig;
  logic              launch;
  logic              fast_zero;
  logic              fast_full;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [FRAC_W-1:0] div_quo;
  logic              pend_q;
  logic [FRAC_W-1:0] slip_q;
  logic              valid_q;
  logic              done_q;

  always_comb begin
    live      = ref_ok_i && brk_ok_i && (vref_i != '0);
    trig      = upd_i || pend_q;
    launch    = live && trig && !div_busy;
    fast_zero = vbrk_i >= vref_i;
    fast_full = vbrk_i == '0;
    div_start = launch && !fast_zero && !fast_full;
  end

  wheel_restoring_div #(.N_W(FRAC_W), .D_W(SPD_W)) u_div (
    .clk(clk), .rst(rst), .start_i(div_start),
    .hi_i(vref_i - vbrk_i), .lo_i('0), .den_i(vref_i),
    .busy_o(div_busy), .done_o(div_done), .quo_o(div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      slip_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!live) begin
        valid_q <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        if (div_done) begin
          slip_q  <= div_quo;
          valid_q <= 1'b1;
          done_q  <= 1'b1;
        end
        if (launch) begin
          pend_q <= 1'b0;
          if (fast_zero) begin
            slip_q  <= '0;
            valid_q <= 1'b1;
            done_q  <= 1'b1;
          end else if (fast_full) begin
            slip_q  <= SLIP_FULL;
            valid_q <= 1'b1;
            done_q  <= 1'b1;
          end
        end else if (trig) begin
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign slip_o  = slip_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;
endmodule

// File: rtl/wheel_slip_meter.sv
module wheel_slip_meter
  import wheel_slip_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int SPD_W   = 16,
  parameter int FRAC_W  = 16,
  parameter int SPEED_K = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tach_i,
  input  logic              brk_tach_i,
  input  logic [CNT_W-1:0]  timeout_i,
  output logic [SPD_W-1:0]  ref_speed_o,
  output logic [SPD_W-1:0]  brk_speed_o,
  output logic [FRAC_W-1:0] slip_o,
  output logic              slip_valid_o,
  output logic              slip_done_o
);
  logic [NUM_CH-1:0] tach;
  logic [SPD_W-1:0]  spd [NUM_CH];
  logic [NUM_CH-1:0] ok;
  logic [NUM_CH-1:0] upd;

  assign tach[REF_IDX] = ref_tach_i;
  assign tach[BRK_IDX] = brk_tach_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    wheel_tach_channel #(
      .CNT_W(CNT_W), .SPD_W(SPD_W), .SPEED_K(SPEED_K), .SYNC_N(2)
    ) u_chan (
      .clk(clk), .rst(rst), .tach_i(tach[g]), .timeout_i(timeout_i),
      .speed_o(spd[g]), .ok_o(ok[g]), .upd_o(upd[g])
    );
  end

  wheel_slip_calc #(.SPD_W(SPD_W), .FRAC_W(FRAC_W)) u_slip (
    .clk(clk), .rst(rst),
    .vref_i(spd[REF_IDX]), .vbrk_i(spd[BRK_IDX]),
    .ref_ok_i(ok[REF_IDX]), .brk_ok_i(ok[BRK_IDX]),
    .upd_i(|upd),
    .slip_o(slip_o), .valid_o(slip_valid_o), .done_o(slip_done_o)
  );

  assign ref_speed_o = spd[REF_IDX];
  assign brk_speed_o = spd[BRK_IDX];
endmodule

// File: rtl/wheel_slip_meter_chk.sv
module wheel_slip_meter_chk #(
  parameter int CNT_W  = 20,
  parameter int SPD_W  = 16,
  parameter int FRAC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_tach_i,
  input logic              brk_tach_i,
  input logic [CNT_W-1:0]  timeout_i,
  input logic [SPD_W-1:0]  ref_speed_o,
  input logic [SPD_W-1:0]  brk_speed_o,
  input logic [FRAC_W-1:0] slip_o,
  input logic              slip_valid_o,
  input logic              slip_done_o
);
  // Independent quiet-time counters on the raw inputs (sync latency covered by margin)
  logic [CNT_W:0]   q_ref;
  logic [CNT_W:0]   q_brk;
  logic             p_ref;
  logic             p_brk;
  logic [CNT_W+1:0] lim;

  assign lim = {2'b00, timeout_i} + (CNT_W+2)'(8);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ref <= '0; q_brk <= '0; p_ref <= 1'b0; p_brk <= 1'b0;
    end else begin
      p_ref <= ref_tach_i;
      p_brk <= brk_tach_i;
      if (ref_tach_i && !p_ref) q_ref <= '0;
      else if (!(&q_ref))       q_ref <= q_ref + 1'b1;
      if (brk_tach_i && !p_brk) q_brk <= '0;
      else if (!(&q_brk))       q_brk <= q_brk + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (slip_o == '0 && !slip_valid_o && !slip_done_o &&
             ref_speed_o == '0 && brk_speed_o == '0));

  a_r9_done_with_valid: assert property (@(posedge clk) disable iff (rst)
    slip_done_o |-> slip_valid_o);

  a_r8_zero_ref_invalid: assert property (@(posedge clk) disable iff (rst)
    (ref_speed_o == '0) |=> !slip_valid_o);

  a_r4_ref_quiet_zero: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, q_ref} > lim) |-> (ref_speed_o == '0));

  a_r4_brk_quiet_zero: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, q_brk} > lim) |-> (brk_speed_o == '0 && !slip_valid_o));
endmodule

bind wheel_slip_meter wheel_slip_meter_chk #(
  .CNT_W(CNT_W), .SPD_W(SPD_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst(rst), .ref_tach_i(ref_tach_i), .brk_tach_i(brk_tach_i),
  .timeout_i(timeout_i), .ref_speed_o(ref_speed_o), .brk_speed_o(brk_speed_o),
  .slip_o(slip_o), .slip_valid_o(slip_valid_o), .slip_done_o(slip_done_o)
);

// File: tb/tb_wheel_slip_meter.sv
`timescale 1ns/1ps
module tb_wheel_slip_meter;
  localparam int CNT_W = 16;
  localparam int SPD_W = 16;
  localparam int FRAC_W = 16;
  localparam int K = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gen_ref = 1'b0, gen_brk = 1'b0, man_ref = 1'b0;
  logic [CNT_W-1:0] tmo = 16'd8000;
  logic [SPD_W-1:0] ref_speed, brk_speed;
  logic [FRAC_W-1:0] slip;
  logic slip_valid, slip_done;
  int ref_per = 0, brk_per = 0;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wheel_slip_meter #(.CNT_W(CNT_W), .SPD_W(SPD_W), .FRAC_W(FRAC_W), .SPEED_K(K)) dut (
    .clk(clk), .rst(rst), .ref_tach_i(gen_ref | man_ref), .brk_tach_i(gen_brk),
    .timeout_i(tmo), .ref_speed_o(ref_speed), .brk_speed_o(brk_speed),
    .slip_o(slip), .slip_valid_o(slip_valid), .slip_done_o(slip_done)
  );

  initial forever begin
    if (ref_per < 2) begin gen_ref = 1'b0; @(negedge clk); end
    else begin
      gen_ref = 1'b1; repeat (ref_per / 2) @(negedge clk);
      gen_ref = 1'b0; repeat (ref_per - ref_per / 2) @(negedge clk);
    end
  end

  initial forever begin
    if (brk_per < 2) begin gen_brk = 1'b0; @(negedge clk); end
    else begin
      gen_brk = 1'b1; repeat (brk_per / 2) @(negedge clk);
      gen_brk = 1'b0; repeat (brk_per - brk_per / 2) @(negedge clk);
    end
  end

  task automatic check(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_slip(input int v, input int w);
    if (w >= v) return 0;
    if (w == 0) return 65535;
    return ((v - w) * 65536) / v;
  endfunction

  task automatic pulse_ref();
    man_ref = 1'b1; repeat (2) @(negedge clk); man_ref = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (slip_done) got = 1'b1;
    end
  endtask

  task automatic run_pair(input int rp, input int bp, input string req);
    bit got;
    int v, w, e;
    ref_per = rp; brk_per = bp;
    repeat (3 * ((rp > bp) ? rp : bp) + 100) @(negedge clk);
    v = K / rp; w = K / bp; e = exp_slip(v, w);
    wait_done(got);
    check(got, {req, " done seen"}, int'(got), 1);
    check(slip_valid == 1'b1, "R9 valid with done", int'(slip_valid), 1);
    check(ref_speed == v && brk_speed == w, "R2 speeds",
          int'(ref_speed) * 65536 + int'(brk_speed), v * 65536 + w);
    check(slip == e, req, int'(slip), e);
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5eed);
    repeat (5) @(negedge clk);
    check(ref_speed == 0 && brk_speed == 0 && slip == 0 && !slip_valid && !slip_done,
          "R1 in reset", int'(slip_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(ref_speed == 0 && slip == 0 && !slip_valid && !slip_done,
          "R1 after reset", int'(ref_speed), 0);

    // R3: first edge only arms; R2: second edge 100 cycles later gives K/100
    pulse_ref(); repeat (48) @(negedge clk);
    check(ref_speed == 0, "R3 first edge no speed", int'(ref_speed), 0);
    repeat (50) @(negedge clk);
    pulse_ref(); repeat (40) @(negedge clk);
    check(ref_speed == 16'(K / 100), "R2 manual period 100", int'(ref_speed), K / 100);

    // R4: timeout clears speed
    tmo = 16'd150;
    repeat (200) @(negedge clk);
    check(ref_speed == 0, "R4 timeout zeroes speed", int'(ref_speed), 0);
    pulse_ref(); repeat (48) @(negedge clk);
    check(ref_speed == 0, "R3 edge after timeout arms only", int'(ref_speed), 0);
    repeat (100) @(negedge clk);
    pulse_ref(); repeat (40) @(negedge clk);
    check(ref_speed == 16'(K / 150), "R4 interval equal to timeout accepted",
          int'(ref_speed), K / 150);
    repeat (109) @(negedge clk);
    pulse_ref(); repeat (40) @(negedge clk);
    check(ref_speed == 0, "R4 interval one over timeout rejected", int'(ref_speed), 0);
    tmo = 16'd8000;

    // Random pairs: R5 / R6
    for (int i = 0; i < 12; i++) begin
      int rp, bp;
      rp = 20 + int'($urandom % 281);
      bp = 20 + int'($urandom % 381);
      run_pair(rp, bp, (K / bp) >= (K / rp) ? "R6 random" : "R5 random");
    end

    run_pair(80, 80, "R6 equal speeds");
    run_pair(200, 100, "R6 braked faster");
    run_pair(97, 131, "R5 directed");
    run_pair(50, 5500, "R7 braked speed zero");

    // R8: reference speed quotient zero
    ref_per = 5500; brk_per = 50;
    repeat (3 * 5500 + 100) @(negedge clk);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        repeat (37) @(negedge clk);
        if (slip_valid || slip_done) bad++;
      end
      check(bad == 0 && ref_speed == 0, "R8 zero reference invalid", bad, 0);
    end

    // R4 at run time: braked channel stops
    run_pair(100, 100, "R6 before stop");
    brk_per = 0;
    repeat (8400) @(negedge clk);
    check(brk_speed == 0 && !slip_valid, "R4 stopped channel invalidates slip",
          int'(brk_speed) + int'(slip_valid), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule